// File: doc/BRIEF.md
# Priority Bus Arbitrator with Acknowledge Timeout

This block is the central arbitration point of a shared bus. It has one direct-memory-access request line and four interrupt request lines at levels 4 to 7. It drives at most one grant line, active low, back onto the bus. The DMA line always wins. An interrupt request is granted only when its level is strictly above the processor's current priority level, and never while that level is being fetched and is therefore not valid.

Once a grant is out, no further grant is issued until a device answers with the selection acknowledge line. If no device answers and every request line has gone quiet, the grant is withdrawn after a programmable number of clock cycles.

The block also keeps a flag that tells the processor a device owns or is about to own the bus. The acknowledge line sets this flag. The flag clears once both acknowledge and bus busy are released, or when an unanswered grant times out. The processor holds off its own data transfers while the flag is set.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, every grant output is high (inactive) and `dev_owns_bus` is 0.
- R2: In a cycle with `sel_ack` high, the next clock edge removes every grant, cancels the acknowledge timeout and sets `dev_owns_bus`.
- R3: With no grant active and `sel_ack` low, a high `dma_req` produces `dma_gnt_n` low after the next edge. This holds whatever the interrupt lines and processor level are.
- R4: With no grant active, `sel_ack` low and `dma_req` low, the highest set bit i of `intr_req` (bit 0 = level 4, bit 3 = level 7) is the candidate level 4+i. Its grant appears on `intr_gnt_n[i]`.
- R5: The interrupt candidate is granted only if its level is strictly greater than `cpu_level`. An equal or lower level yields no grant.
- R6: While `cpu_level_valid` is 0, no interrupt grant is issued.
- R7: While a grant is active and `sel_ack` is low, the grant outputs do not change to a different grant, even if a higher-precedence request appears.
- R8: If a grant was issued at edge E0 and from then on no request line and no acknowledge is high, the grant is still present after edge E0+TIMEOUT_CYC. It is removed at edge E0+TIMEOUT_CYC+1, and that edge also clears `dev_owns_bus`.
- R9: `dev_owns_bus` clears on an edge where both `sel_ack` and `bus_busy` are low. It holds while only `bus_busy` is high, and `sel_ack` high without `bus_busy` sets it.
- R10: At most one of the five grant outputs is low at any time.
- R11: A grant whose timeout has expired is kept for as long as any request line remains high, and it is dropped on the first edge after all requests go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | DMA (non-processor) request line |
| intr_req | input | 4 | Interrupt request lines, bit i = level 4+i |
| sel_ack | input | 1 | Selection acknowledge from the granted device |
| bus_busy | input | 1 | Bus busy line |
| cpu_level | input | 3 | Processor current priority level |
| cpu_level_valid | input | 1 | Processor level is valid (0 while it is being fetched) |
| dma_gnt_n | output | 1 | DMA grant, active low |
| intr_gnt_n | output | 4 | Interrupt grants, active low, bit i = level 4+i |
| dev_owns_bus | output | 1 | A device owns or has claimed the bus |

## Verification
The hardest situation to reach is the timeout path. It needs an unanswered grant that outlives its window while request lines are still held, followed by removal of every request. It also needs the ownership flag set beforehand, so that clearing it by timeout is visible at all. The bench first sets ownership with an acknowledge and keeps bus busy high so the idle rule cannot clear it. It then issues a grant and counts edges exactly to the withdrawal point. Separately, it holds a request well past the window before releasing it. All 512 combinations of request lines, processor level and validity are swept from the idle state, with the expected grant computed by a priority search in the bench.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_BR = 4;
  localparam int GNT_W = NUM_BR + 1;
  localparam int DMA_IDX = NUM_BR;
  localparam logic [2:0] LVL_BASE = 3'd4;

  typedef logic [GNT_W-1:0] gnt_vec_t;

  // Level of the highest asserted interrupt line (bit i -> LVL_BASE+i)
  function automatic logic [2:0] top_level(input logic [NUM_BR-1:0] req);
    logic [2:0] lvl;
    lvl = LVL_BASE;
    for (int i = 0; i < NUM_BR; i++) begin
      if (req[i]) lvl = LVL_BASE + 3'(i);
    end
    return lvl;
  endfunction

  // One-hot grant bit for an interrupt level
  function automatic logic [NUM_BR-1:0] level_bit(input logic [2:0] lvl);
    logic [NUM_BR-1:0] b;
    b = '0;
    for (int i = 0; i < NUM_BR; i++) begin
      if (lvl == LVL_BASE + 3'(i)) b[i] = 1'b1;
    end
    return b;
  endfunction
endpackage

// File: rtl/arb_req_eval.sv
module arb_req_eval
  import arb_pkg::*;
(
  input  logic [NUM_BR-1:0] intr_req,
  input  logic [2:0]        cpu_level,
  input  logic              cpu_level_valid,
  output logic              br_any,
  output logic [2:0]        br_lvl,
  output logic              br_win,
  output logic [NUM_BR-1:0] br_onehot
);
  always_comb begin
    br_any    = |intr_req;
    br_lvl    = top_level(intr_req);
    br_win    = br_any && cpu_level_valid && (br_lvl > cpu_level);
    br_onehot = level_bit(br_lvl);
  end
endmodule

// File: rtl/arb_ack_timer.sv
module arb_ack_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cancel,
  input  logic armed,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cancel) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_INIT;
    end else if (armed && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = armed && (cnt_q == '0);
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_req,
  input  logic [NUM_BR-1:0] intr_req,
  input  logic              sel_ack,
  input  logic              bus_busy,
  input  logic [2:0]        cpu_level,
  input  logic              cpu_level_valid,
  output logic              dma_gnt_n,
  output logic [NUM_BR-1:0] intr_gnt_n,
  output logic              dev_owns_bus
);
  gnt_vec_t gnt_q;
  logic     owns_q;

  logic              br_any, br_win;
  logic [2:0]        br_lvl;
  logic [NUM_BR-1:0] br_onehot;
  logic              tmo_expired;

  // named events
  logic gnt_idle, issue_dma, issue_br, tmo_drop, idle_clear, any_req;

  arb_req_eval u_eval (
    .intr_req        (intr_req),
    .cpu_level       (cpu_level),
    .cpu_level_valid (cpu_level_valid),
    .br_any          (br_any),
    .br_lvl          (br_lvl),
    .br_win          (br_win),
    .br_onehot       (br_onehot)
  );

  always_comb begin
    gnt_idle   = (gnt_q == '0);
    any_req    = dma_req || br_any;
    issue_dma  = !sel_ack && dma_req && gnt_idle;
    issue_br   = !sel_ack && !dma_req && br_win && gnt_idle;
    tmo_drop   = !sel_ack && !any_req && !gnt_idle && tmo_expired;
    idle_clear = !sel_ack && !bus_busy;
  end

  arb_ack_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (issue_dma || issue_br),
    .cancel  (sel_ack),
    .armed   (!gnt_idle),
    .expired (tmo_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      owns_q <= 1'b0;
    end else begin
      if (idle_clear) owns_q <= 1'b0;
      if (sel_ack) begin
        gnt_q  <= '0;
        owns_q <= 1'b1;
      end else if (issue_dma) begin
        gnt_q <= GNT_W'(1) << DMA_IDX;
      end else if (issue_br) begin
        gnt_q <= {1'b0, br_onehot};
      end else if (tmo_drop) begin
        gnt_q  <= '0;
        owns_q <= 1'b0;
      end
    end
  end

  assign dma_gnt_n    = ~gnt_q[DMA_IDX];
  assign intr_gnt_n   = ~gnt_q[NUM_BR-1:0];
  assign dev_owns_bus = owns_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int TIMEOUT_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dma_req,
  input logic [3:0] intr_req,
  input logic       sel_ack,
  input logic       bus_busy,
  input logic       cpu_level_valid,
  input logic       dma_gnt_n,
  input logic [3:0] intr_gnt_n,
  input logic       dev_owns_bus
);
  logic [4:0]  gnt;
  logic [31:0] quiet_cnt;
  assign gnt = ~{dma_gnt_n, intr_gnt_n};

  always_ff @(posedge clk) begin
    if (!rst_n) quiet_cnt <= '0;
    else if (gnt != '0 && !sel_ack && !dma_req && intr_req == '0)
      quiet_cnt <= quiet_cnt + 1;
    else quiet_cnt <= '0;
  end

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ack |=> (gnt == '0) && dev_owns_bus);

  // R3
  dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !sel_ack && dma_req) |=> (gnt == 5'b10000));

  // R6
  fetch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !sel_ack && !dma_req && !cpu_level_valid) |=> (gnt == '0));

  // R7
  no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !sel_ack) |=> (gnt == '0 || $stable(gnt)));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ack && !bus_busy) |=> !dev_owns_bus);

  // R8
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_cnt <= 32'(TIMEOUT_CYC + 1));
endmodule

bind prio_bus_arbiter arb_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .dma_req         (dma_req),
  .intr_req        (intr_req),
  .sel_ack         (sel_ack),
  .bus_busy        (bus_busy),
  .cpu_level_valid (cpu_level_valid),
  .dma_gnt_n       (dma_gnt_n),
  .intr_gnt_n      (intr_gnt_n),
  .dev_owns_bus    (dev_owns_bus)
);

// File: tb/prio_bus_arbiter_tb.sv
module prio_bus_arbiter_tb;
  localparam int TMO = 8;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       dma_req = 0;
  logic [3:0] intr_req = 0;
  logic       sel_ack = 0;
  logic       bus_busy = 0;
  logic [2:0] cpu_level = 0;
  logic       cpu_level_valid = 1;
  logic       dma_gnt_n;
  logic [3:0] intr_gnt_n;
  logic       dev_owns_bus;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  prio_bus_arbiter #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .intr_req(intr_req),
    .sel_ack(sel_ack), .bus_busy(bus_busy), .cpu_level(cpu_level),
    .cpu_level_valid(cpu_level_valid), .dma_gnt_n(dma_gnt_n),
    .intr_gnt_n(intr_gnt_n), .dev_owns_bus(dev_owns_bus)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_gnt(input string req, input logic [4:0] exp_n);
    n_chk++;
    if ({dma_gnt_n, intr_gnt_n} !== exp_n) begin
      n_bad++;
      $display("FAIL %s grants got %b expected %b", req, {dma_gnt_n, intr_gnt_n}, exp_n);
    end
  endtask

  task automatic check_own(input string req, input logic exp);
    n_chk++;
    if (dev_owns_bus !== exp) begin
      n_bad++;
      $display("FAIL %s owns got %b expected %b", req, dev_owns_bus, exp);
    end
  endtask

  function automatic logic [4:0] expect_n(input logic d, input logic [3:0] br,
                                          input int lvl, input logic vld);
    int hi;
    hi = -1;
    if (d) return 5'b01111;
    for (int i = 3; i >= 0; i--) if (br[i] && hi < 0) hi = i;
    if (hi >= 0 && vld && (hi + 4) > lvl) return ~(5'b00001 << hi);
    return 5'b11111;
  endfunction

  task automatic clear_all();
    dma_req = 0; intr_req = 0; sel_ack = 1; bus_busy = 0;
    step();
    sel_ack = 0;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    // R1
    check_gnt("R1", 5'b11111);
    check_own("R1", 1'b0);
    rst_n = 1;

    // R3 R4 R5 R6 R2 R9: sweep from idle
    for (int c = 0; c < 512; c++) begin
      dma_req = c[0];
      intr_req = c[4:1];
      cpu_level = c[7:5];
      cpu_level_valid = c[8];
      step();
      check_gnt("R3/R4/R5/R6 sweep", expect_n(c[0], c[4:1], int'(c[7:5]), c[8]));
      dma_req = 0; intr_req = 0; sel_ack = 1; bus_busy = 0;
      step();
      check_gnt("R2 ack removes grant", 5'b11111);
      check_own("R2 ack sets owner", 1'b1);
      sel_ack = 0;
      step();
      check_own("R9 idle clears owner", 1'b0);
    end

    // R9: busy alone holds ownership
    sel_ack = 1; bus_busy = 1; step();
    sel_ack = 0; step(); step();
    check_own("R9 busy holds owner", 1'b1);

    // R7: grant BR5, then a DMA request does not change it
    cpu_level = 0; cpu_level_valid = 1;
    intr_req = 4'b0010; step();
    check_gnt("R7 initial", 5'b11101);
    dma_req = 1; intr_req = 4'b1000; step(); step();
    check_gnt("R7 no regrant", 5'b11101);

    // R11: requests held past window keep the grant
    for (int k = 0; k < 3 * TMO; k++) step();
    check_gnt("R11 held", 5'b11101);
    dma_req = 0; intr_req = 0; step();
    check_gnt("R11 released", 5'b11111);
    check_own("R8 timeout clears owner", 1'b0);

    // R8: exact window, owner set beforehand and busy high
    sel_ack = 1; bus_busy = 1; step();
    sel_ack = 0;
    dma_req = 1; step();
    check_gnt("R8 issued", 5'b01111);
    dma_req = 0;
    for (int k = 0; k < TMO - 1; k++) step();
    check_gnt("R8 before window end", 5'b01111);
    check_own("R8 owner kept", 1'b1);
    step();
    check_gnt("R8 before window end", 5'b01111);
    step();
    check_gnt("R8 withdrawn", 5'b11111);
    check_own("R8 owner cleared", 1'b0);

    // R2: ack cancels timer; next grant gets a full window
    bus_busy = 0;
    intr_req = 4'b0100; step();
    sel_ack = 1; intr_req = 0; step();
    sel_ack = 0; intr_req = 4'b1000; step();
    check_gnt("R2 new grant", 5'b10111);
    intr_req = 0;
    for (int k = 0; k < TMO; k++) step();
    check_gnt("R2 full window", 5'b10111);
    step();
    check_gnt("R2 window end", 5'b11111);

    // R10 spot: all requests at once
    clear_all();
    dma_req = 1; intr_req = 4'hF; step();
    check_gnt("R10 single grant", 5'b01111);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule